// File: doc/BRIEF.md
# Flash Read Prefetch FIFO Engine

This block sits between a byte-wide flash data port and a host processor. Software sets up a transfer through four word-wide registers. The setup gives the chip-select to present, the transfer direction, an enable, a FIFO threshold and a byte count. Software then writes the start bit. The engine pulls the requested number of bytes from the flash port into a 64-byte FIFO and pauses whenever the FIFO is full. The host drains the FIFO as little-endian 32-bit words from a single read port.

A status register shows how many bytes are still to be fetched and how many bytes sit in the FIFO. Software can therefore read `fill / 4` whole words in a burst. While a transfer runs, the engine refuses any new setup or a second start. Writing zero to the control register aborts the transfer and empties the FIFO. Only the read direction is built. A setup that selects write-posting can be stored, but it cannot be started.

Top module: `flash_prefetch`

## Requirements
- R1: After reset, every register reads 0, `fl_req` is low, `fifo_valid` is low and `fifo_thresh` is high.
- R2: The setup register sits at address 0. Bit 0 is the direction (0 = read, 1 = write-post). Bit 7 is the enable. Bits [14:8] hold the threshold and bits [26:24] the chip-select. All other bits read back as 0, and `fl_cs` follows the stored chip-select field.
- R3: A setup write whose threshold field exceeds 64 is ignored as a whole. A threshold of exactly 64 is accepted.
- R4: While a transfer is active, writes to the setup register (address 0) and the count register (address 1, bits [13:0]) have no effect. A further start write neither reloads the count nor empties the FIFO.
- R5: Writing 1 in bit 0 of the control register (address 2) starts a transfer only if the engine is idle, the enable is 1 and the direction is 0. A start empties the FIFO, loads the remaining count from the count register, and makes the control register read 1. A start write that fails these conditions is ignored.
- R6: Writing 0 in bit 0 of the control register stops the engine. The control register then reads 0, the remaining count is 0 and the FIFO is empty.
- R7: `fl_req` is high only while a transfer is active, the remaining count is nonzero and the FIFO holds fewer than 64 bytes. Each cycle with `fl_req` and `fl_ack` both high stores `fl_data` and decrements the remaining count. The control register clears by itself once the count reaches 0.
- R8: The status register (address 3) carries the remaining count in bits [13:0] and the FIFO fill level in bytes in bits [30:24]. All other bits are 0.
- R9: `fifo_valid` is high while at least 4 bytes are stored. A cycle with `fifo_rd` high and `fifo_valid` high removes 4 bytes. `fifo_rdata` presents the oldest byte in bits [7:0] and the newest of the four in bits [31:24].
- R10: `fifo_thresh` is high exactly when the fill level is at least the threshold field.
- R11: A start with a count of 0 ends at once. The control register reads 0 after it, and no flash request is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| fl_req | output | 1 | Engine wants a byte from flash |
| fl_ack | input | 1 | Flash presents a byte this cycle |
| fl_data | input | 8 | Flash byte |
| fl_cs | output | 3 | Chip-select from the setup register |
| fifo_rd | input | 1 | Host pops one 32-bit word |
| fifo_valid | output | 1 | At least one whole word is stored |
| fifo_rdata | output | 32 | Oldest word, little-endian |
| fifo_thresh | output | 1 | Fill level has reached the threshold |

## Verification
Some properties are checked on every cycle:
- the fill level never passes 64, and no byte is pushed into a full FIFO;
- a pop never takes a partial word, and a flush always leaves the FIFO empty;
- an active transfer always has a nonzero remaining count, and every flash handshake lowers that count by one;
- the setup and count registers stay frozen while a transfer runs, and the stored threshold never exceeds 64.

Other behaviour is only visible through the bench scenarios:
- the byte order inside the drained words;
- the stall at a full FIFO and the resume as words are drained;
- refused starts, aborts and zero-length transfers;
- the exact threshold crossing and the register bit layout.

// File: rtl/flash_pf_pkg.sv
package flash_pf_pkg;

    localparam int PF_DEPTH    = 64;
    localparam int PF_LANES    = 4;
    localparam int PF_BYTE_W   = 8;
    localparam int PF_WORD_W   = PF_LANES * PF_BYTE_W;
    localparam int PF_CNT_W    = 14;
    localparam int PF_CS_W     = 3;
    localparam int PF_THR_W    = 7;
    localparam int PF_FILL_W   = $clog2(PF_DEPTH) + 1;

    // Field positions inside the setup and status words
    localparam int PF_DIR_BIT   = 0;
    localparam int PF_EN_BIT    = 7;
    localparam int PF_THR_LSB   = 8;
    localparam int PF_CS_LSB    = 24;
    localparam int PF_FILL_LSB  = 24;

    typedef enum logic [1:0] {
        PF_REG_SETUP  = 2'd0,
        PF_REG_COUNT  = 2'd1,
        PF_REG_CTRL   = 2'd2,
        PF_REG_STATUS = 2'd3
    } pf_reg_e;

    typedef struct packed {
        logic [PF_CS_W-1:0]  cs;
        logic [PF_THR_W-1:0] thr;
        logic                en;
        logic                dir;
    } pf_setup_t;

    function automatic logic [PF_WORD_W-1:0] pf_setup_pack(pf_setup_t s);
        logic [PF_WORD_W-1:0] w;
        w = '0;
        w[PF_DIR_BIT]               = s.dir;
        w[PF_EN_BIT]                = s.en;
        w[PF_THR_LSB +: PF_THR_W]   = s.thr;
        w[PF_CS_LSB  +: PF_CS_W]    = s.cs;
        return w;
    endfunction

    function automatic pf_setup_t pf_setup_unpack(logic [PF_WORD_W-1:0] w);
        pf_setup_t s;
        s.dir = w[PF_DIR_BIT];
        s.en  = w[PF_EN_BIT];
        s.thr = w[PF_THR_LSB +: PF_THR_W];
        s.cs  = w[PF_CS_LSB  +: PF_CS_W];
        return s;
    endfunction

    function automatic logic [PF_WORD_W-1:0] pf_status_pack(
        logic [PF_CNT_W-1:0]  rem,
        logic [PF_FILL_W-1:0] fill
    );
        logic [PF_WORD_W-1:0] w;
        w = '0;
        w[PF_CNT_W-1:0]                = rem;
        w[PF_FILL_LSB +: PF_FILL_W]    = fill;
        return w;
    endfunction

endpackage

// File: rtl/flash_pf_fifo.sv
module flash_pf_fifo
    import flash_pf_pkg::*;
#(
    parameter int DEPTH  = PF_DEPTH,
    parameter int LANES  = PF_LANES,
    parameter int FILL_W = $clog2(DEPTH) + 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    flush,
    input  logic                    push,
    input  logic [PF_BYTE_W-1:0]    push_byte,
    input  logic                    pop,
    output logic [FILL_W-1:0]       fill,
    output logic [LANES*PF_BYTE_W-1:0] word
);

    localparam int AW = $clog2(DEPTH);

    logic [PF_BYTE_W-1:0] mem [DEPTH];
    logic [AW-1:0]        wr_ptr;
    logic [AW-1:0]        rd_ptr;
    logic [FILL_W-1:0]    fill_nxt;

    always_comb begin
        fill_nxt = fill + FILL_W'(push);
        if (pop) begin
            fill_nxt = fill_nxt - FILL_W'(LANES);
        end
    end

    always_ff @(posedge clk) begin
        if (push && !flush) begin
            mem[wr_ptr] <= push_byte;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (push) begin
                wr_ptr <= wr_ptr + 1'b1;
            end
            if (pop) begin
                rd_ptr <= rd_ptr + AW'(LANES);
            end
            fill <= fill_nxt;
        end
    end

    // Little-endian word assembly: lane 0 is the oldest byte
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign word[l*PF_BYTE_W +: PF_BYTE_W] = mem[AW'(rd_ptr + AW'(l))];
    end

    AST_FILL_BOUND: assert property (@(posedge clk) disable iff (rst)
        fill <= FILL_W'(DEPTH)) else $error("fill above depth"); // R7

    AST_NO_PUSH_FULL: assert property (@(posedge clk) disable iff (rst)
        push |-> (fill < FILL_W'(DEPTH))) else $error("push into full FIFO"); // R7

    AST_POP_WHOLE_WORD: assert property (@(posedge clk) disable iff (rst)
        pop |-> (fill >= FILL_W'(LANES))) else $error("pop of partial word"); // R9

    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (rst)
        flush |=> (fill == '0)) else $error("flush left data"); // R6

endmodule

// File: rtl/flash_pf_fetch.sv
module flash_pf_fetch
    import flash_pf_pkg::*;
#(
    parameter int CNT_W  = PF_CNT_W,
    parameter int DEPTH  = PF_DEPTH,
    parameter int FILL_W = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              stop,
    input  logic [CNT_W-1:0]  load_cnt,
    input  logic [FILL_W-1:0] fill,
    input  logic              fl_ack,
    output logic              active,
    output logic [CNT_W-1:0]  remaining,
    output logic              fl_req,
    output logic              push
);

    assign fl_req = active && (remaining != '0) && (fill < FILL_W'(DEPTH));
    assign push   = fl_req && fl_ack;

    always_ff @(posedge clk) begin
        if (rst || stop) begin
            active    <= 1'b0;
            remaining <= '0;
        end else if (start) begin
            active    <= (load_cnt != '0);
            remaining <= load_cnt;
        end else if (push) begin
            remaining <= remaining - 1'b1;
            if (remaining == CNT_W'(1)) begin
                active <= 1'b0;
            end
        end
    end

    AST_ACTIVE_HAS_WORK: assert property (@(posedge clk) disable iff (rst)
        active |-> (remaining != '0)) else $error("active with zero count"); // R7

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (push && !stop) |=> (remaining == CNT_W'($past(remaining) - 1'b1)))
        else $error("count did not step"); // R7

endmodule

// File: rtl/flash_pf_regs.sv
module flash_pf_regs
    import flash_pf_pkg::*;
#(
    parameter int CNT_W   = PF_CNT_W,
    parameter int FILL_W  = PF_FILL_W,
    parameter int THR_MAX = PF_DEPTH
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 reg_wr,
    input  logic [1:0]           reg_addr,
    input  logic [PF_WORD_W-1:0] reg_wdata,
    input  logic                 active,
    input  logic [CNT_W-1:0]     remaining,
    input  logic [FILL_W-1:0]    fill,
    output pf_setup_t            setup,
    output logic [CNT_W-1:0]     count,
    output logic                 start,
    output logic                 stop,
    output logic [PF_WORD_W-1:0] reg_rdata
);

    pf_reg_e   sel;
    pf_setup_t wr_setup;
    logic      thr_ok;
    logic      ctrl_wr;

    assign sel      = pf_reg_e'(reg_addr);
    assign wr_setup = pf_setup_unpack(reg_wdata);
    assign thr_ok   = (int'(wr_setup.thr) <= THR_MAX);
    assign ctrl_wr  = reg_wr && (sel == PF_REG_CTRL);

    assign start = ctrl_wr && reg_wdata[0] && !active && setup.en && !setup.dir;
    assign stop  = ctrl_wr && !reg_wdata[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            setup <= '0;
            count <= '0;
        end else if (reg_wr && !active) begin
            if (sel == PF_REG_SETUP && thr_ok) begin
                setup <= wr_setup;
            end
            if (sel == PF_REG_COUNT) begin
                count <= reg_wdata[CNT_W-1:0];
            end
        end
    end

    always_comb begin
        unique case (sel)
            PF_REG_SETUP:  reg_rdata = pf_setup_pack(setup);
            PF_REG_COUNT:  reg_rdata = PF_WORD_W'(count);
            PF_REG_CTRL:   reg_rdata = PF_WORD_W'(active);
            PF_REG_STATUS: reg_rdata = pf_status_pack(PF_CNT_W'(remaining), PF_FILL_W'(fill));
            default:       reg_rdata = '0;
        endcase
    end

    AST_SETUP_FROZEN: assert property (@(posedge clk) disable iff (rst)
        active |=> $stable(setup)) else $error("setup changed in transfer"); // R4

    AST_COUNT_FROZEN: assert property (@(posedge clk) disable iff (rst)
        active |=> $stable(count)) else $error("count changed in transfer"); // R4

    AST_THR_LIMIT: assert property (@(posedge clk) disable iff (rst)
        int'(setup.thr) <= THR_MAX) else $error("threshold above limit"); // R3

endmodule

// File: rtl/flash_prefetch.sv
module flash_prefetch
    import flash_pf_pkg::*;
#(
    parameter int DEPTH = PF_DEPTH,
    parameter int CNT_W = PF_CNT_W
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        fl_req,
    input  logic        fl_ack,
    input  logic [7:0]  fl_data,
    output logic [2:0]  fl_cs,
    input  logic        fifo_rd,
    output logic        fifo_valid,
    output logic [31:0] fifo_rdata,
    output logic        fifo_thresh
);

    localparam int FILL_W = $clog2(DEPTH) + 1;

    pf_setup_t          setup;
    logic [CNT_W-1:0]   count;
    logic [CNT_W-1:0]   remaining;
    logic [FILL_W-1:0]  fill;
    logic               start;
    logic               stop;
    logic               active;
    logic               push;
    logic               pop;

    assign fifo_valid  = (fill >= FILL_W'(PF_LANES));
    assign pop         = fifo_rd && fifo_valid;
    assign fl_cs       = setup.cs;
    assign fifo_thresh = (fill >= FILL_W'(setup.thr));

    flash_pf_regs #(
        .CNT_W   (CNT_W),
        .FILL_W  (FILL_W),
        .THR_MAX (DEPTH)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .active    (active),
        .remaining (remaining),
        .fill      (fill),
        .setup     (setup),
        .count     (count),
        .start     (start),
        .stop      (stop),
        .reg_rdata (reg_rdata)
    );

    flash_pf_fetch #(
        .CNT_W  (CNT_W),
        .DEPTH  (DEPTH),
        .FILL_W (FILL_W)
    ) u_fetch (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .stop      (stop),
        .load_cnt  (count),
        .fill      (fill),
        .fl_ack    (fl_ack),
        .active    (active),
        .remaining (remaining),
        .fl_req    (fl_req),
        .push      (push)
    );

    flash_pf_fifo #(
        .DEPTH  (DEPTH),
        .LANES  (PF_LANES),
        .FILL_W (FILL_W)
    ) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .flush     (start || stop),
        .push      (push),
        .push_byte (fl_data),
        .pop       (pop),
        .fill      (fill),
        .word      (fifo_rdata)
    );

endmodule

// File: tb/flash_prefetch_bench.sv
module flash_prefetch_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        fl_req;
    logic        fl_ack;
    logic [7:0]  fl_data;
    logic [2:0]  fl_cs;
    logic        fifo_rd = 1'b0;
    logic        fifo_valid;
    logic [31:0] fifo_rdata;
    logic        fifo_thresh;
    logic        ack_en = 1'b0;
    int          flash_idx = 0;
    int          checks = 0;
    int          errors = 0;

    always #2 clk = ~clk;

    function automatic logic [7:0] pat(int i);
        return 8'((i * 37) + 5);
    endfunction

    function automatic logic [31:0] mk_setup(bit dir, bit en, int thr, int cs);
        return (32'(cs) << 24) | (32'(thr) << 8) | (32'(en) << 7) | 32'(dir);
    endfunction

    assign fl_ack  = ack_en && fl_req;
    assign fl_data = pat(flash_idx);

    always @(posedge clk) begin
        if (fl_req && fl_ack) flash_idx <= flash_idx + 1;
    end

    flash_prefetch u_flash_prefetch (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fl_req(fl_req),
        .fl_ack(fl_ack), .fl_data(fl_data), .fl_cs(fl_cs), .fifo_rd(fifo_rd),
        .fifo_valid(fifo_valid), .fifo_rdata(fifo_rdata), .fifo_thresh(fifo_thresh)
    );

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic ack_cycles(int n);
        @(negedge clk);
        ack_en = 1'b1;
        repeat (n) @(negedge clk);
        ack_en = 1'b0;
    endtask

    task automatic wait_idle();
        logic [31:0] c;
        int t = 0;
        rd(2'd2, c);
        while (c != 0 && t < 5000) begin rd(2'd2, c); t++; end
    endtask

    task automatic drain(int nwords, int base, string req);
        for (int w = 0; w < nwords; w++) begin
            int t = 0;
            logic [31:0] exp;
            @(negedge clk);
            while (!fifo_valid && t < 2000) begin @(negedge clk); t++; end
            exp = {pat(base + 4*w + 3), pat(base + 4*w + 2), pat(base + 4*w + 1), pat(base + 4*w)};
            chk(req, "drained word", fifo_rdata, exp);
            fifo_rd = 1'b1;
            @(negedge clk);
            fifo_rd = 1'b0;
        end
    endtask

    task automatic t_reset();
        logic [31:0] d;
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), d);
            chk("R1", "register after reset", d, 0);
        end
        chk("R1", "fl_req after reset", 32'(fl_req), 0);
        chk("R1", "fifo_valid after reset", 32'(fifo_valid), 0);
        chk("R1", "fifo_thresh after reset", 32'(fifo_thresh), 1);
    endtask

    task automatic t_setup_layout();
        logic [31:0] d;
        wr(2'd0, mk_setup(0, 1, 16, 5) | 32'hF8FF_807E);
        rd(2'd0, d);
        chk("R2", "setup readback drops other bits", d, mk_setup(0, 1, 16, 5));
        chk("R2", "fl_cs follows setup", 32'(fl_cs), 5);
        wr(2'd0, mk_setup(1, 0, 65, 2));
        rd(2'd0, d);
        chk("R3", "threshold 65 rejected", d, mk_setup(0, 1, 16, 5));
        wr(2'd0, mk_setup(0, 1, 64, 1));
        rd(2'd0, d);
        chk("R3", "threshold 64 accepted", d, mk_setup(0, 1, 64, 1));
    endtask

    task automatic t_basic();
        logic [31:0] d;
        int base;
        wr(2'd1, 32'd12);
        base = flash_idx;
        ack_en = 1'b1;
        wr(2'd2, 32'd1);
        wait_idle();
        ack_en = 1'b0;
        rd(2'd3, d);
        chk("R8", "status after 12-byte fetch", d, 32'd12 << 24);
        chk("R7", "fl_req low after auto-clear", 32'(fl_req), 0);
        drain(3, base, "R9");
        rd(2'd3, d);
        chk("R9", "status after drain", d, 0);
    endtask

    task automatic t_full_pause();
        logic [31:0] d;
        int base;
        wr(2'd1, 32'd100);
        base = flash_idx;
        wr(2'd2, 32'd1);
        ack_en = 1'b1;
        repeat (80) @(negedge clk);
        rd(2'd3, d);
        chk("R7", "fetch pauses at full FIFO", d, (32'd64 << 24) | 32'd36);
        chk("R7", "fl_req low while full", 32'(fl_req), 0);
        rd(2'd2, d);
        chk("R7", "still active while paused", d, 1);
        drain(25, base, "R7");
        wait_idle();
        ack_en = 1'b0;
        rd(2'd3, d);
        chk("R7", "status after long transfer", d, 0);
    endtask

    task automatic t_busy_and_stop();
        logic [31:0] d;
        wr(2'd0, mk_setup(0, 1, 8, 2));
        wr(2'd1, 32'd40);
        wr(2'd2, 32'd1);
        rd(2'd2, d);
        chk("R5", "control reads 1 after start", d, 1);
        wr(2'd0, mk_setup(0, 1, 4, 6));
        rd(2'd0, d);
        chk("R4", "setup write ignored while busy", d, mk_setup(0, 1, 8, 2));
        wr(2'd1, 32'd7);
        rd(2'd1, d);
        chk("R4", "count write ignored while busy", d, 40);
        ack_cycles(10);
        wr(2'd2, 32'd1);
        rd(2'd3, d);
        chk("R4", "restart ignored while busy", d, (32'd10 << 24) | 32'd30);
        wr(2'd2, 32'd0);
        rd(2'd2, d);
        chk("R6", "control after stop", d, 0);
        rd(2'd3, d);
        chk("R6", "status after stop", d, 0);
        chk("R6", "fl_req after stop", 32'(fl_req), 0);
    endtask

    task automatic t_refused_starts();
        logic [31:0] d;
        ack_en = 1'b1;
        wr(2'd0, mk_setup(0, 0, 8, 0));
        wr(2'd1, 32'd5);
        wr(2'd2, 32'd1);
        rd(2'd2, d);
        chk("R5", "start refused with enable 0", d, 0);
        rd(2'd3, d);
        chk("R5", "no bytes with enable 0", d, 0);
        wr(2'd0, mk_setup(1, 1, 8, 0));
        wr(2'd2, 32'd1);
        rd(2'd2, d);
        chk("R5", "start refused in write-post", d, 0);
        rd(2'd3, d);
        chk("R5", "no bytes in write-post", d, 0);
        wr(2'd0, mk_setup(0, 1, 8, 0));
        wr(2'd1, 32'd0);
        wr(2'd2, 32'd1);
        rd(2'd2, d);
        chk("R11", "zero-count start ends at once", d, 0);
        chk("R11", "no request on zero count", 32'(fl_req), 0);
        rd(2'd3, d);
        chk("R11", "status after zero-count start", d, 0);
        ack_en = 1'b0;
    endtask

    task automatic t_odd_count();
        logic [31:0] d;
        int base;
        wr(2'd1, 32'd6);
        base = flash_idx;
        ack_en = 1'b1;
        wr(2'd2, 32'd1);
        wait_idle();
        ack_en = 1'b0;
        rd(2'd3, d);
        chk("R8", "status holds 6 bytes", d, 32'd6 << 24);
        chk("R9", "valid with 6 bytes", 32'(fifo_valid), 1);
        drain(1, base, "R9");
        rd(2'd3, d);
        chk("R9", "2 bytes left after pop", d, 32'd2 << 24);
        chk("R9", "not valid with 2 bytes", 32'(fifo_valid), 0);
        wr(2'd2, 32'd0);
    endtask

    task automatic t_threshold();
        logic [31:0] d;
        wr(2'd0, mk_setup(0, 1, 8, 3));
        wr(2'd1, 32'd20);
        wr(2'd2, 32'd1);
        ack_cycles(7);
        rd(2'd3, d);
        chk("R10", "fill 7 bytes", d, (32'd7 << 24) | 32'd13);
        chk("R10", "below threshold", 32'(fifo_thresh), 0);
        ack_cycles(1);
        @(negedge clk);
        chk("R10", "at threshold", 32'(fifo_thresh), 1);
        wr(2'd2, 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_setup_layout();
        t_basic();
        t_full_pause();
        t_busy_and_stop();
        t_refused_starts();
        t_odd_count();
        t_threshold();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule